// File: doc/BRIEF.md
# Byte-Wide Programmable Read-Only Memory Model with Identifier Mode

This block is a synthesizable behavioural model of a byte-wide, one-way-programmable read-only memory. It works out its operating mode from four control inputs: an active-low chip select that also serves as the program strobe, an active-low output enable, a flag meaning that programming voltage is present, and a flag meaning that a high voltage is present on the identifier address pin. From that mode it serves reads, output disable, deselect, byte programming, program verify, program inhibit, and an identifier mode that returns two fixed code bytes.

Programming can only clear bits. Each program cycle stores the old byte ANDed with the byte on the data input. An erase input and reset both return every location to all ones. The array is a small register memory whose depth is set by a parameter. Analog levels are modelled as digital flags and access delays are not modelled. In place of a tri-state bus the model drives an explicit output-enable signal, so a testbench that uses it as a device model can check every high-impedance case.

Top module: `eprom_model`

## Requirements
- R1: With the chip select low, output enable low and both voltage flags clear, `dout_en` is 1 and `dout` shows the stored byte at `addr` in the same cycle. With the chip select low, output enable high and the programming flag clear, `dout_en` is 0. Whenever `dout_en` is 0, `dout` is 00h.
- R2: With the chip select high, `dout_en` is 0 whatever the state of the output enable and both voltage flags.
- R3: With the programming flag set, the chip select low and the output enable high, the byte at `addr` becomes the old byte AND `din` at the rising clock edge, and `dout_en` is 0 during that cycle.
- R4: With the programming flag set, the chip select low and the output enable low (verify), the stored byte at `addr` is driven with `dout_en` 1 and nothing is written.
- R5: With the programming flag set and the chip select high (inhibit), nothing is written.
- R6: With the high-voltage flag set, the programming flag clear, chip select and output enable low, and `addr` bits 1 and up all zero, `addr[0]`=0 returns 01h and `addr[0]`=1 returns 9Bh.
- R7: Both identifier bytes have an odd number of ones, and bit 7 is the parity bit over bits 6 to 0.
- R8: In the identifier selection of R6, if any `addr` bit from 1 upward is set, `dout_en` is 0.
- R9: A rising clock edge with `rst_n` low sets every location to FFh.
- R10: A rising clock edge with `erase` high sets every location to FFh, and takes priority over a program write in the same cycle.
- R11: When both voltage flags are set, the programming flag wins. Verify and program behave as in R3 and R4, and no identifier byte is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes, erase and reset take effect at its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, fills the array with ones |
| ce_n | input | 1 | Active-low chip select and program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage present on the identifier address pin |
| erase | input | 1 | Erase request, fills the array with ones |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Output byte, 00h when not driven |
| dout_en | output | 1 | Output drive enable; 0 stands for high impedance |

## Verification
The assertions assume that the control inputs stay stable across each rising edge, and that any erase or program request they see comes after reset has been released for at least one cycle. The write-side checks compare the byte after an edge with the value read before it, so they rely on `addr` being held through the write edge. The stimulus changes every input just after a falling edge and holds it through the next rising edge. It also gives one full clock cycle of release after reset before it issues any write or erase.

// File: rtl/eprom_pkg.sv
// Package: shared mode encoding and identifier payloads for the memory model.
// Assumes an 8-bit data path; identifier bytes carry a parity bit in bit 7.
package eprom_pkg;

    localparam int DATA_W = 8;

    // Seven-bit identifier payloads; the parity bit is added in hardware.
    localparam logic [6:0] ID_MAKER_PAYLOAD  = 7'h01;
    localparam logic [6:0] ID_DEVICE_PAYLOAD = 7'h1B;

    typedef enum logic [2:0] {
        MD_DESELECT = 3'd0,
        MD_READ     = 3'd1,
        MD_QUIET    = 3'd2,
        MD_PROGRAM  = 3'd3,
        MD_VERIFY   = 3'd4,
        MD_INHIBIT  = 3'd5,
        MD_IDENT    = 3'd6,
        MD_ID_BAD   = 3'd7
    } mode_t;

endpackage

// File: rtl/eprom_mode_dec.sv
// Module: eprom_mode_dec
// Decodes the operating mode from the control pins and voltage flags.
// Assumes the programming flag outranks the identifier high-voltage flag.
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    input  logic  upper_zero,
    output mode_t mode
);

    // Priority decode: deselect, then programming, then identifier, then read.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MD_INHIBIT : MD_DESELECT;
        end else if (vpp_hi) begin
            mode = oe_n ? MD_PROGRAM : MD_VERIFY;
        end else if (oe_n) begin
            mode = MD_QUIET;
        end else if (a9_hv) begin
            mode = upper_zero ? MD_IDENT : MD_ID_BAD;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/eprom_id_rom.sv
// Module: eprom_id_rom
// Returns the maker or device identifier byte, adding odd parity in bit 7.
// Assumes the payloads come from the package and are 7 bits wide.
module eprom_id_rom
    import eprom_pkg::*;
(
    input  logic              sel_device,
    output logic [DATA_W-1:0] code
);

    logic [6:0] payload;

    // Pick the payload and add the bit that makes the count of ones odd.
    always_comb begin
        payload = sel_device ? ID_DEVICE_PAYLOAD : ID_MAKER_PAYLOAD;
        code    = {~(^payload), payload};
    end

endmodule

// File: rtl/eprom_array.sv
// Module: eprom_array
// Register array with an asynchronous read port and a clear-only write port.
// A write stores old AND wdata; reset and erase fill every location with ones.
// Assumes addr and wdata are held stable across the write edge.
module eprom_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_go;

    assign wr_go = rst_n & we & ~erase;
    assign rdata = mem[addr];

    // Fill with ones on reset or erase; otherwise clear bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_go) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_go) |-> ((mem[$past(addr)] & ~$past(rdata)) == '0)); // R3
    AST_ERASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rdata == '1)); // R10

endmodule

// File: rtl/eprom_model.sv
// Module: eprom_model
// Byte-wide one-way-programmable memory model with identifier mode.
// Drives dout_en in place of a tri-state bus; dout is zero when not driven.
// Assumes control inputs change away from the rising clock edge.
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    mode_t             mode;
    logic              upper_zero;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] id_code;
    logic              write_req;

    // Identifier selection needs every address bit above bit 0 low.
    generate
        if (ADDR_W > 1) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:1] == '0);
        end else begin : g_single
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign write_req = (mode == MD_PROGRAM);

    eprom_mode_dec u_dec (
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .vpp_hi     (vpp_hi),
        .a9_hv      (a9_hv),
        .upper_zero (upper_zero),
        .mode       (mode)
    );

    eprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .we    (write_req),
        .addr  (addr),
        .wdata (din),
        .rdata (rd_data)
    );

    eprom_id_rom u_id (
        .sel_device (addr[0]),
        .code       (id_code)
    );

    // Output mux: array data for read and verify, code for identifier.
    always_comb begin
        dout    = '0;
        dout_en = 1'b0;
        case (mode)
            MD_READ, MD_VERIFY: begin
                dout    = rd_data;
                dout_en = 1'b1;
            end
            MD_IDENT: begin
                dout    = id_code;
                dout_en = 1'b1;
            end
            default: begin
                dout    = '0;
                dout_en = 1'b0;
            end
        endcase
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en); // R2
    AST_PROGRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && vpp_hi) |-> !dout_en); // R3
    AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (a9_hv && !vpp_hi && !ce_n && !oe_n && dout_en) |-> (^dout)); // R7
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00)); // R1

endmodule

// File: tb/sim_eprom_model.sv
// Bench: near-exhaustive sweep over a 16-byte configuration of the model.
module sim_eprom_model;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          a9_hv = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    logic [7:0] shadow [DEPTH];
    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic exp_en, input logic [7:0] exp_d);
        vectors++;
        if (dout_en !== exp_en || dout !== exp_d) begin
            fails++;
            $display("FAIL %s addr=%0h: got en=%b d=%02h, expected en=%b d=%02h",
                     req, addr, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic set_ctl(input logic c, input logic o, input logic v, input logic h);
        ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h;
    endtask

    // Read every location in plain read mode against the shadow copy.
    task automatic sweep_read(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
            addr = AW'(a);
            #2 check(req, 1'b1, shadow[a]);
        end
    endtask

    // One clock edge with the given controls, then return to idle.
    task automatic pulse(input logic c, input logic o, input logic v, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        set_ctl(c, o, v, 1'b0);
        addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) shadow[a] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: after reset every byte reads FFh.
        sweep_read("R9");

        // R2 / R1: all control combinations with chip select high, and quiet read.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            set_ctl(1'b1, k[0], k[1], k[2]);
            #2 check("R2", 1'b0, 8'h00);
        end
        @(negedge clk);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        #2 check("R1", 1'b0, 8'h00);
        @(negedge clk);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
        #2 check("R1", 1'b0, 8'h00);

        // R3: two program passes; each stores old AND din; no drive while programming.
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < DEPTH; a++) begin
                logic [7:0] d;
                d = (pass == 0) ? 8'((a * 29 + 7)) : 8'((a * 53) ^ 8'hA5);
                @(negedge clk);
                set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
                addr = AW'(a); din = d;
                #2 check("R3", 1'b0, 8'h00);
                @(posedge clk);
                shadow[a] = shadow[a] & d;
            end
        end
        sweep_read("R3");

        // R5: inhibit (chip select high, programming flag set) must not write.
        for (int a = 0; a < DEPTH; a++) pulse(1'b1, 1'b1, 1'b1, AW'(a), 8'h00);
        sweep_read("R5");

        // R4: verify drives stored data and does not write.
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
            addr = AW'(a); din = 8'h00;
            #2 check("R4", 1'b1, shadow[a]);
        end
        sweep_read("R4");

        // R6 / R7: identifier bytes and their parity.
        for (int s = 0; s < 2; s++) begin
            logic [7:0] exp_id;
            exp_id = (s == 0) ? 8'h01 : 8'h9B;
            @(negedge clk);
            set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
            addr = AW'(s);
            #2 check("R6", 1'b1, exp_id);
            vectors++;
            if ((^dout) !== 1'b1 || dout[7] !== ~(^dout[6:0])) begin
                fails++;
                $display("FAIL R7: got %02h, expected odd parity in bit 7", dout);
            end
        end

        // R8: identifier with any upper address bit set is not driven.
        for (int a = 2; a < DEPTH; a++) begin
            @(negedge clk);
            set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
            addr = AW'(a);
            #2 check("R8", 1'b0, 8'h00);
        end

        // R11: both flags set: verify returns array data, program writes.
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        addr = AW'(1);
        #2 check("R11", 1'b1, shadow[1]);
        @(negedge clk);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        addr = AW'(0); din = 8'h0F;
        #2 check("R11", 1'b0, 8'h00);
        @(posedge clk);
        shadow[0] = shadow[0] & 8'h0F;
        sweep_read("R11");

        // R10: erase fills ones and wins over a program write in the same cycle.
        @(negedge clk);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        addr = AW'(3); din = 8'h00; erase = 1'b1;
        @(posedge clk);
        @(negedge clk);
        erase = 1'b0;
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        for (int a = 0; a < DEPTH; a++) shadow[a] = 8'hFF;
        sweep_read("R10");

        // R9: program again, then reset restores all ones.
        pulse(1'b0, 1'b1, 1'b1, AW'(5), 8'h3C);
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        addr = AW'(5);
        #2 check("R3", 1'b1, 8'h3C);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep_read("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule